// File: doc/BRIEF.md
# Buffered Serial Port with Self-Sizing Transmit Frames

This block is a full-duplex asynchronous serial port. The transmit side has one holding register in front of a shift register. A word written into the holding register moves into the shift register as soon as the shift register is free. The length of each outgoing frame comes from the written word itself. The highest set bit of the word marks where the trailing stop bits begin, and every bit from bit 0 up to that one is shifted out after a low start bit.

The receive side synchronises the serial input and qualifies a start bit at half a bit period. It then samples each later bit at mid-bit. It assembles either eight data bits plus a stop bit, or nine data bits plus a stop bit in long mode. A finished frame is copied into a receive holding register.

A single read word gives software everything at once: the received bits, the overrun, receive-full, transmit-empty and shift-empty flags, and the raw level of the serial input pin. The bit period is programmed in clock cycles.

Top module: `sio_uart`

## Requirements
- R1: After reset, `rd_word[15:12]` reads 0,0,1,1 (overrun 0, receive full 0, transmit buffer empty 1, shift register empty 1), `rd_word[9:0]` reads 0 and `txd` is high.
- R2: A write (`tx_wr` high for one cycle) clears the transmit-empty flag `rd_word[13]` (mirrored on `irq_tbe`) at the next edge. When the shift register is empty, the held word moves into it one edge later. That move sets `rd_word[13]` and clears the shift-empty flag `rd_word[12]`.
- R3: A frame is one low start bit, then the written word least significant bit first up to and including its highest 1, then `txd` idles high and `rd_word[12]` is set. Every bit lasts `baud`+1 clocks.
- R4: A word written while a frame is shifting waits in the holding register. A further write before the move replaces it. The held word starts after exactly one idle-high clock following the end of the previous frame.
- R5: Frame length follows the highest set bit: 0x0003 sends 2 bits after the start bit, 0x0155 sends 9, 0x0300 sends 10 and 0x8001 sends 16.
- R6: In normal mode (`long_mode`=0) the receiver takes 8 data bits and one stop bit. Data appears in `rd_word[7:0]` and the stop bit appears in both `rd_word[9]` and `rd_word[8]`.
- R7: In long mode (`long_mode`=1) the receiver takes 9 data bits and one stop bit. `rd_word[8:0]` is data and `rd_word[9]` is the stop bit.
- R8: A completed frame sets receive-full `rd_word[14]` (mirrored on `irq_rbf`). A one-cycle `rx_clr` clears it.
- R9: A frame that completes while receive-full is set raises overrun `rd_word[15]` and overwrites the received data. Overrun then stays set until `rx_clr`.
- R10: `rd_word[11]` follows the `rxd` pin combinationally and `rd_word[10]` reads 0.
- R11: A low pulse on `rxd` shorter than half a bit period does not start a frame, and receive-full stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 16 | Transmit word, stop bits above data |
| baud | input | BAUD_W | Bit period minus one, in clocks |
| long_mode | input | 1 | Receiver takes 9 data bits when high |
| rx_clr | input | 1 | Clears receive-full and overrun |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rd_word | output | 16 | Status and receive data read word |
| irq_tbe | output | 1 | Transmit-buffer-empty request |
| irq_rbf | output | 1 | Receive-buffer-full request |

## Verification
The bench drives back-to-back writes, an overwritten held word and words whose highest bit sits at positions 1, 8, 9 and 15. A design that derived length from a fixed field, or that dropped or doubled the gap between frames, would shift `txd` against the clock-by-clock model. On the receive side it sends normal and long frames, a frame landing on a full buffer, and a sub-half-period glitch. A wrong overrun rule would lose the flag or keep stale data, and a missing start check would assemble a phantom frame out of the glitch.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int WORD_W = 16;
    localparam int RX_W   = 10;
    localparam int IDX_W  = 4;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2
    } rx_st_e;
endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int BAUD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BAUD_W-1:0] baud,
    output logic              txd,
    output logic              tbe,
    output logic              tsre
);
    localparam int SH_W = WORD_W + 1;

    typedef struct packed {
        logic              busy;
        logic [SH_W-1:0]   sh;
        logic [BAUD_W-1:0] cnt;
        logic [WORD_W-1:0] hold;
        logic              full;
        logic              tbe;
    } tx_st_t;

    tx_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy && s_q.full) begin
            // move held word behind a low start bit
            s_d.sh   = {s_q.hold, 1'b0};
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.full = 1'b0;
            s_d.tbe  = 1'b1;
        end else if (s_q.busy) begin
            if (s_q.cnt == baud) begin
                s_d.cnt = '0;
                s_d.sh  = s_q.sh >> 1;
                // frame ends after the highest set bit leaves
                if (s_q.sh[SH_W-1:1] == '0) begin
                    s_d.busy = 1'b0;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (wr) begin
            s_d.hold = wdata;
            s_d.full = 1'b1;
            s_d.tbe  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.tbe  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = s_q.busy ? s_q.sh[0] : 1'b1;
    assign tbe  = s_q.tbe;
    assign tsre = !s_q.busy;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int BAUD_W = 12,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [BAUD_W-1:0] baud,
    input  logic              long_mode,
    input  logic              clr,
    output logic [RX_W-1:0]   rbuf,
    output logic              rbf,
    output logic              ovr
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        rx_st_e            st;
        logic [BAUD_W-1:0] cnt;
        logic [IDX_W-1:0]  idx;
        logic [RX_W-1:0]   sh;
        logic [RX_W-1:0]   rbuf;
        logic              rbf;
        logic              ovr;
    } rx_st_t;

    rx_st_t s_d, s_q;
    logic   rxs;
    logic   done;
    logic [BAUD_W-1:0] half;
    logic [IDX_W-1:0]  last;
    logic [RX_W-1:0]   frame;

    assign rxs  = s_q.sync[SYNC_N-1];
    assign half = baud >> 1;
    assign last = long_mode ? IDX_W'(9) : IDX_W'(8);

    always_comb begin
        s_d      = s_q;
        done     = 1'b0;
        s_d.sync = {s_q.sync[SYNC_N-2:0], rxd};
        case (s_q.st)
            RX_IDLE: begin
                if (!rxs) begin
                    s_d.st  = RX_START;
                    s_d.cnt = '0;
                end
            end
            RX_START: begin
                if (s_q.cnt == half) begin
                    s_d.cnt = '0;
                    s_d.idx = '0;
                    s_d.st  = rxs ? RX_IDLE : RX_DATA;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (s_q.cnt == baud) begin
                    s_d.cnt         = '0;
                    s_d.sh[s_q.idx] = rxs;
                    s_d.idx         = s_q.idx + 1'b1;
                    if (s_q.idx == last) begin
                        done   = 1'b1;
                        s_d.st = RX_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = RX_IDLE;
        endcase
        frame = long_mode ? s_d.sh : {s_d.sh[8], s_d.sh[8:0]};
        if (clr) begin
            s_d.rbf = 1'b0;
            s_d.ovr = 1'b0;
        end
        if (done) begin
            s_d.rbuf = frame;
            s_d.rbf  = 1'b1;
            if (s_q.rbf && !clr) begin
                s_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= '1;
            s_q.st   <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rbuf = s_q.rbuf;
    assign rbf  = s_q.rbf;
    assign ovr  = s_q.ovr;
endmodule

// File: rtl/sio_uart.sv
module sio_uart
    import sio_pkg::*;
#(
    parameter int BAUD_W = 12,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [15:0]       tx_wdata,
    input  logic [BAUD_W-1:0] baud,
    input  logic              long_mode,
    input  logic              rx_clr,
    input  logic              rxd,
    output logic              txd,
    output logic [15:0]       rd_word,
    output logic              irq_tbe,
    output logic              irq_rbf
);
    logic            tbe, tsre, rbf, ovr;
    logic [RX_W-1:0] rbuf;

    sio_tx #(.BAUD_W(BAUD_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (tx_wr),
        .wdata (tx_wdata),
        .baud  (baud),
        .txd   (txd),
        .tbe   (tbe),
        .tsre  (tsre)
    );

    sio_rx #(.BAUD_W(BAUD_W), .SYNC_N(SYNC_N)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .baud      (baud),
        .long_mode (long_mode),
        .clr       (rx_clr),
        .rbuf      (rbuf),
        .rbf       (rbf),
        .ovr       (ovr)
    );

    assign rd_word = {ovr, rbf, tbe, tsre, rxd, 1'b0, rbuf};
    assign irq_tbe = tbe;
    assign irq_rbf = rbf;
endmodule

// File: rtl/sio_uart_chk.sv
module sio_uart_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_wr,
    input logic        rx_clr,
    input logic        txd,
    input logic [15:0] rd_word
);
    AST_WR_CLEARS_TBE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !rd_word[13]); // R2

    AST_LOAD_SETS_TBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_word[12]) && !$past(tx_wr)) |-> rd_word[13]); // R2

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_word[12]) |-> !txd); // R3

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_word[15]) |-> $past(rd_word[14])); // R9

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word[15] && !rx_clr) |=> rd_word[15]); // R9
endmodule

bind sio_uart sio_uart_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_wr   (tx_wr),
    .rx_clr  (rx_clr),
    .txd     (txd),
    .rd_word (rd_word)
);

// File: tb/tb_sio_uart.sv
module tb_sio_uart;
    localparam int CLK_PERIOD = 10;
    localparam int BW         = 12;
    localparam int BAUD       = 7;
    localparam int P          = BAUD + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_wr = 1'b0;
    logic [15:0]   tx_wdata = '0;
    logic [BW-1:0] baud = BW'(BAUD);
    logic          long_mode = 1'b0;
    logic          rx_clr = 1'b0;
    logic          rxd = 1'b1;
    logic          txd;
    logic [15:0]   rd_word;
    logic          irq_tbe, irq_rbf;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 0;

    sio_uart #(.BAUD_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .baud(baud), .long_mode(long_mode), .rx_clr(rx_clr), .rxd(rxd),
        .txd(txd), .rd_word(rd_word), .irq_tbe(irq_tbe), .irq_rbf(irq_rbf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // behavioural transmit model: a queue of bits, each held P clocks
    bit       m_busy, m_full, m_tbe;
    logic [15:0] m_hold;
    int       m_cnt;
    bit       m_bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_full = 0; m_tbe = 1; m_hold = '0; m_cnt = 0;
            m_bits.delete();
        end else begin
            if (!m_busy && m_full) begin
                int hi;
                hi = -1;
                for (int i = 0; i < 16; i++) if (m_hold[i]) hi = i;
                m_bits.push_back(1'b0);
                for (int i = 0; i <= hi; i++) m_bits.push_back(m_hold[i]);
                m_busy = 1; m_cnt = 0; m_full = 0; m_tbe = 1;
            end else if (m_busy) begin
                if (m_cnt == BAUD) begin
                    m_cnt = 0;
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) m_busy = 0;
                end else begin
                    m_cnt++;
                end
            end
            if (tx_wr) begin
                m_hold = tx_wdata; m_full = 1; m_tbe = 0;
            end
        end
    end

    // compare on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 R5 txd", {15'b0, txd}, {15'b0, (m_busy ? m_bits[0] : 1'b1)});
            chk("R2 R4 tbe flag", {15'b0, rd_word[13]}, {15'b0, m_tbe});
            chk("R2 irq_tbe", {15'b0, irq_tbe}, {15'b0, m_tbe});
            chk("R2 R3 tsre flag", {15'b0, rd_word[12]}, {15'b0, !m_busy});
        end
    end

    task automatic write(input logic [15:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic tx_drain();
        do @(negedge clk); while (m_busy || m_full);
    endtask

    task automatic send_rx(input int nbits, input logic [9:0] bits);
        @(negedge clk);
        rxd = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd = bits[i];
            repeat (P) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); rx_clr = 1'b1;
        @(negedge clk); rx_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {12'b0, rd_word[15:12]}, 16'h0003);
        chk("R1 data", {6'b0, rd_word[9:0]}, 16'h0000);
        chk("R1 txd", {15'b0, txd}, 16'h0001);

        // R3 R5 back-to-back frames; R4 held word waits
        write(16'h0155);
        write(16'h0003);
        tx_drain();
        write(16'h0300);
        tx_drain();
        write(16'h8001);
        tx_drain();
        // R4 overwrite of held word while shifting
        write(16'h01AA);
        write(16'h0111);
        write(16'h0122);
        tx_drain();
        repeat (4) @(negedge clk);

        // R6 normal frame
        send_rx(9, {1'b1, 1'b1, 8'hA5});
        chk("R6 normal data", {6'b0, rd_word[9:0]}, 16'h03A5);
        chk("R8 rbf set", {15'b0, rd_word[14]}, 16'h0001);
        chk("R8 irq_rbf", {15'b0, irq_rbf}, 16'h0001);
        chk("R9 no overrun", {15'b0, rd_word[15]}, 16'h0000);
        pulse_clr();
        chk("R8 rbf cleared", {15'b0, rd_word[14]}, 16'h0000);

        // R7 long frame
        long_mode = 1'b1;
        send_rx(10, {1'b1, 9'h1C3});
        chk("R7 long data", {6'b0, rd_word[9:0]}, 16'h03C3);
        chk("R7 rbf", {15'b0, rd_word[14]}, 16'h0001);
        // R9 overrun with overwrite
        send_rx(10, {1'b1, 9'h055});
        chk("R9 overwrite", {6'b0, rd_word[9:0]}, 16'h0255);
        chk("R9 overrun set", {15'b0, rd_word[15]}, 16'h0001);
        repeat (20) @(negedge clk);
        chk("R9 overrun held", {15'b0, rd_word[15]}, 16'h0001);
        pulse_clr();
        chk("R9 overrun cleared", {14'b0, rd_word[15:14]}, 16'h0000);

        // R10 live pin and zero bit
        @(negedge clk);
        rxd = 1'b0; #1;
        chk("R10 pin low", {15'b0, rd_word[11]}, 16'h0000);
        chk("R10 bit10", {15'b0, rd_word[10]}, 16'h0000);
        rxd = 1'b1; #1;
        chk("R10 pin high", {15'b0, rd_word[11]}, 16'h0001);

        // R11 short glitch rejected
        long_mode = 1'b0;
        @(negedge clk); rxd = 1'b0;
        repeat (2) @(negedge clk); rxd = 1'b1;
        repeat (4 * P) @(negedge clk);
        chk("R11 glitch ignored", {15'b0, rd_word[14]}, 16'h0000);
        send_rx(9, {1'b1, 1'b1, 8'h3C});
        chk("R6 R11 frame after glitch", {6'b0, rd_word[9:0]}, 16'h033C);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule